// File: doc/BRIEF.md
# USB Endpoint DMA Request and Interrupt Controller

This block sits beside the endpoint FIFOs of a USB device controller and drives the request lines of an external DMA engine. It has three transmit and three receive DMA channels. Each channel carries a 4-bit endpoint selection. Channels 0 to 2 serve transmit endpoints and channels 3 to 5 serve receive endpoints. For each endpoint, the controller also takes a DMA enable bit and an interrupt mode bit, given separately for the transmit and receive directions. The block follows the ready flag of the selected endpoint FIFO. It raises a burst request whenever the channel is enabled, its FIFO can move a whole packet and the channel still has packets left to move.

Software arms a channel by loading a transfer length, counted in packets (whole FIFO loads). The DMA engine pulses a per-channel packet-done input each time it has moved one packet, and the channel counts down. The per-endpoint mode bit selects when the channel's sticky status bit is set: after every packet, or only after the last packet of the transfer. In both modes the requests continue until the count reaches zero. All channel status bits, ORed with the rest of the USB interrupt sources, drive one shared interrupt output. The handler reads the status vector to find the channel that completed and writes ones to clear it.

Top module: `usb_dma_req_ctrl`

## Requirements
- R1: After reset, every `dma_req` bit, every `dma_irq_stat` bit and the packet counts are zero. `usb_irq` is low while `usb_irq_in` is low.
- R2: Channel c takes the endpoint number held in `ch_ep_sel[4c+3:4c]`. The values 0 and 8 to 15 mean the channel is unmapped. Channels 0 to 2 use the transmit enable, ready and mode vectors, and channels 3 to 5 use the receive vectors, each indexed by the endpoint number.
- R3: `dma_req[c]` is high in the cycle after an edge at which the channel is mapped, its endpoint DMA enable is 1, its endpoint FIFO ready is 1 and its packet count after that edge is non-zero.
- R4: `dma_req[c]` is low in the cycle after an edge at which the FIFO ready is 0 or the channel is disabled. It is never high for an unmapped channel.
- R5: A pulse on `len_wr[c]` loads `len_wdata` as the packet count. This load takes priority over a packet-done pulse in the same cycle. The request drops at the same edge that counts the last packet.
- R6: With the endpoint mode bit at 0, every counted packet-done pulse sets `dma_irq_stat[c]` at the following edge.
- R7: With the mode bit at 1, `dma_irq_stat[c]` is set only by the packet-done pulse that takes the count from 1 to 0.
- R8: `dma_irq_stat[c]` stays set until `irq_clr[c]` is 1 at an edge. A new set in the same cycle as a clear wins.
- R9: `usb_irq` is high exactly when any `dma_irq_stat` bit is high or `usb_irq_in` is high.
- R10: A packet-done pulse on a channel whose count is zero, or which is unmapped or disabled, changes neither its count, its request nor its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_ep_sel | input | 24 | Endpoint number for each channel, 4 bits per channel |
| ep_dma_en_tx | input | 8 | DMA enable for each transmit endpoint |
| ep_dma_en_rx | input | 8 | DMA enable for each receive endpoint |
| ep_irq_mode_tx | input | 8 | Interrupt mode for each transmit endpoint (0 per packet, 1 per transfer) |
| ep_irq_mode_rx | input | 8 | Interrupt mode for each receive endpoint |
| fifo_rdy_tx | input | 8 | Transmit FIFO can accept a packet |
| fifo_rdy_rx | input | 8 | Receive FIFO holds a packet |
| len_wr | input | 6 | Per-channel strobe that loads the transfer length |
| len_wdata | input | 8 | Transfer length in packets |
| ch_pkt_done | input | 6 | DMA engine finished moving one packet on the channel |
| irq_clr | input | 6 | Write-one-to-clear strobes for the status bits |
| usb_irq_in | input | 1 | The other USB interrupt sources, already combined |
| dma_req | output | 6 | Burst request for each channel |
| dma_irq_stat | output | 6 | Sticky completion status for each channel |
| usb_irq | output | 1 | Shared USB interrupt line |

## Verification
The hardest situation to reach is a status set and a software clear landing on the same edge, combined with the per-transfer mode, where only the final packet may fire. The bench arms a receive channel in per-transfer mode and walks it through its non-final packets while checking that the status stays low. It then gives the final packet-done pulse in the same cycle as that channel's clear strobe. Unmapped selections, a disabled endpoint and an exhausted count all receive packet-done pulses, which shows that each is ignored. A reference model in the bench runs every cycle and feeds the scoreboard.

// File: rtl/usb_dma_pkg.sv
package usb_dma_pkg;
  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

  // Direction served by a channel: lower half transmit, upper half receive.
  function automatic dir_e dir_of(input int ch, input int per_dir);
    return (ch < per_dir) ? DIR_TX : DIR_RX;
  endfunction

  // Status set rule: per-packet mode fires on each counted packet,
  // per-transfer mode only on the packet that empties the count.
  function automatic logic irq_fire(input logic mode, input logic counted, input logic last);
    return counted && (!mode || last);
  endfunction
endpackage

// File: rtl/usb_dma_ch_map.sv
module usb_dma_ch_map #(
  parameter int NUM_EP = 8,
  parameter int EP_W   = 4
) (
  input  logic [EP_W-1:0]   sel,
  input  logic [NUM_EP-1:0] en_vec,
  input  logic [NUM_EP-1:0] rdy_vec,
  input  logic [NUM_EP-1:0] mode_vec,
  output logic              ch_en,
  output logic              ch_rdy,
  output logic              ch_mode
);
  always_comb begin
    ch_en   = 1'b0;
    ch_rdy  = 1'b0;
    ch_mode = 1'b0;
    for (int e = 0; e < NUM_EP; e++) begin
      if (e != 0 && sel == EP_W'(e)) begin
        ch_en   = en_vec[e];
        ch_rdy  = rdy_vec[e];
        ch_mode = mode_vec[e];
      end
    end
  end
endmodule

// File: rtl/usb_dma_ch_ctr.sv
module usb_dma_ch_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_en,
  input  logic             ch_rdy,
  input  logic             ch_mode,
  input  logic             len_wr,
  input  logic [CNT_W-1:0] len_wdata,
  input  logic             pkt_done,
  output logic             req,
  output logic             irq_set,
  output logic             busy,
  output logic             evt_pkt,
  output logic             evt_last
);
  logic [CNT_W-1:0] rem_q, rem_d;

  assign busy     = (rem_q != '0);
  assign evt_pkt  = pkt_done && ch_en && busy && !len_wr;
  assign evt_last = evt_pkt && (rem_q == CNT_W'(1));
  assign irq_set  = usb_dma_pkg::irq_fire(ch_mode, evt_pkt, evt_last);

  always_comb begin
    if (len_wr)       rem_d = len_wdata;
    else if (evt_pkt) rem_d = rem_q - CNT_W'(1);
    else              rem_d = rem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      req   <= 1'b0;
    end else begin
      rem_q <= rem_d;
      req   <= ch_en && ch_rdy && (rem_d != '0);
    end
  end
endmodule

// File: rtl/usb_dma_irq_agg.sv
module usb_dma_irq_agg #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] irq_set,
  input  logic [NCH-1:0] irq_clr,
  input  logic           usb_irq_in,
  output logic [NCH-1:0] stat,
  output logic           irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~irq_clr) | irq_set;
  end

  assign irq = (|stat) || usb_irq_in;
endmodule

// File: rtl/usb_dma_req_ctrl.sv
module usb_dma_req_ctrl #(
  parameter int NUM_EP  = 8,
  parameter int EP_W    = 4,
  parameter int PER_DIR = 3,
  parameter int CNT_W   = 8,
  localparam int NCH    = 2 * PER_DIR
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH*EP_W-1:0] ch_ep_sel,
  input  logic [NUM_EP-1:0]   ep_dma_en_tx,
  input  logic [NUM_EP-1:0]   ep_dma_en_rx,
  input  logic [NUM_EP-1:0]   ep_irq_mode_tx,
  input  logic [NUM_EP-1:0]   ep_irq_mode_rx,
  input  logic [NUM_EP-1:0]   fifo_rdy_tx,
  input  logic [NUM_EP-1:0]   fifo_rdy_rx,
  input  logic [NCH-1:0]      len_wr,
  input  logic [CNT_W-1:0]    len_wdata,
  input  logic [NCH-1:0]      ch_pkt_done,
  input  logic [NCH-1:0]      irq_clr,
  input  logic                usb_irq_in,
  output logic [NCH-1:0]      dma_req,
  output logic [NCH-1:0]      dma_irq_stat,
  output logic                usb_irq
);
  import usb_dma_pkg::*;

  // Named per-channel events, visible to the bound checker.
  logic [NCH-1:0] ch_en, ch_rdy, ch_mode, ch_busy, ch_evt_pkt, ch_evt_last, ch_irq_set;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (dir_of(c, PER_DIR) == DIR_TX) begin : g_tx
      usb_dma_ch_map #(.NUM_EP(NUM_EP), .EP_W(EP_W)) map_i (
        .sel(ch_ep_sel[c*EP_W +: EP_W]), .en_vec(ep_dma_en_tx),
        .rdy_vec(fifo_rdy_tx), .mode_vec(ep_irq_mode_tx),
        .ch_en(ch_en[c]), .ch_rdy(ch_rdy[c]), .ch_mode(ch_mode[c]));
    end else begin : g_rx
      usb_dma_ch_map #(.NUM_EP(NUM_EP), .EP_W(EP_W)) map_i (
        .sel(ch_ep_sel[c*EP_W +: EP_W]), .en_vec(ep_dma_en_rx),
        .rdy_vec(fifo_rdy_rx), .mode_vec(ep_irq_mode_rx),
        .ch_en(ch_en[c]), .ch_rdy(ch_rdy[c]), .ch_mode(ch_mode[c]));
    end

    usb_dma_ch_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en[c]), .ch_rdy(ch_rdy[c]),
      .ch_mode(ch_mode[c]), .len_wr(len_wr[c]), .len_wdata(len_wdata),
      .pkt_done(ch_pkt_done[c]), .req(dma_req[c]), .irq_set(ch_irq_set[c]),
      .busy(ch_busy[c]), .evt_pkt(ch_evt_pkt[c]), .evt_last(ch_evt_last[c]));
  end

  usb_dma_irq_agg #(.NCH(NCH)) agg_i (
    .clk(clk), .rst_n(rst_n), .irq_set(ch_irq_set), .irq_clr(irq_clr),
    .usb_irq_in(usb_irq_in), .stat(dma_irq_stat), .irq(usb_irq));
endmodule

// File: rtl/usb_dma_req_chk.sv
module usb_dma_req_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dma_req,
  input logic [NCH-1:0] dma_irq_stat,
  input logic           usb_irq,
  input logic           usb_irq_in,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] ch_rdy,
  input logic [NCH-1:0] ch_mode,
  input logic [NCH-1:0] ch_busy,
  input logic [NCH-1:0] ch_evt_pkt,
  input logic [NCH-1:0] ch_evt_last,
  input logic [NCH-1:0] len_wr,
  input logic [NCH-1:0] irq_clr
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_req_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[i] && ch_rdy[i] && ch_busy[i] && !ch_evt_pkt[i] && !len_wr[i]) |=> dma_req[i]);
    p_req_drop_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_rdy[i] |=> !dma_req[i]);
    p_req_drop_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |=> !dma_req[i]);
    p_last_drops_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_evt_last[i] |=> !dma_req[i]);
    p_pkt_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_evt_pkt[i] && !ch_mode[i]) |=> dma_irq_stat[i]);
    p_xfer_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_evt_pkt[i] && ch_mode[i] && !ch_evt_last[i] && !dma_irq_stat[i]) |=> !dma_irq_stat[i]);
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_irq_stat[i] && !irq_clr[i]) |=> dma_irq_stat[i]);
  end

  p_shared_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_irq_stat != '0) |-> usb_irq);
endmodule

bind usb_dma_req_ctrl usb_dma_req_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_irq_stat(dma_irq_stat),
  .usb_irq(usb_irq), .usb_irq_in(usb_irq_in), .ch_en(ch_en), .ch_rdy(ch_rdy),
  .ch_mode(ch_mode), .ch_busy(ch_busy), .ch_evt_pkt(ch_evt_pkt),
  .ch_evt_last(ch_evt_last), .len_wr(len_wr), .irq_clr(irq_clr));

// File: tb/usb_dma_req_ctrl_tb.sv
module usb_dma_req_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] ch_ep_sel = '0;
  logic [7:0]  en_tx = '0, en_rx = '0, md_tx = '0, md_rx = '0, rdy_tx = '0, rdy_rx = '0;
  logic [5:0]  len_wr = '0, pkt_done = '0, irq_clr = '0;
  logic [7:0]  len_wdata = '0;
  logic        usb_irq_in = 1'b0;
  logic [5:0]  dma_req, dma_irq_stat;
  logic        usb_irq;

  usb_dma_req_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ch_ep_sel(ch_ep_sel),
    .ep_dma_en_tx(en_tx), .ep_dma_en_rx(en_rx),
    .ep_irq_mode_tx(md_tx), .ep_irq_mode_rx(md_rx),
    .fifo_rdy_tx(rdy_tx), .fifo_rdy_rx(rdy_rx),
    .len_wr(len_wr), .len_wdata(len_wdata), .ch_pkt_done(pkt_done),
    .irq_clr(irq_clr), .usb_irq_in(usb_irq_in),
    .dma_req(dma_req), .dma_irq_stat(dma_irq_stat), .usb_irq(usb_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string      tag;
    int         kind;   // 0 request vector, 1 status vector, 2 interrupt line
    logic [5:0] exp;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  // Reference state kept by the bench.
  int         m_rem [NCH];
  logic [5:0] m_stat = '0;

  function automatic void set_sel(input int c, input int ep);
    ch_ep_sel[c*4 +: 4] = 4'(ep);
  endfunction

  // Driver: compute what the next edge must produce and push it.
  task automatic cyc();
    logic [5:0] req_e, set_e;
    req_e = '0; set_e = '0;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) m_rem[c] = 0;
      m_stat = '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int  ep;
        bit  en, rdy, md, cnt;
        int  nxt;
        ep = int'(ch_ep_sel[c*4 +: 4]);
        en = 0; rdy = 0; md = 0;
        if (ep >= 1 && ep <= 7) begin
          en  = (c < 3) ? en_tx[ep]  : en_rx[ep];
          rdy = (c < 3) ? rdy_tx[ep] : rdy_rx[ep];
          md  = (c < 3) ? md_tx[ep]  : md_rx[ep];
        end
        cnt = pkt_done[c] && en && (m_rem[c] != 0) && !len_wr[c];
        if (cnt && (!md || m_rem[c] == 1)) set_e[c] = 1'b1;
        nxt = len_wr[c] ? int'(len_wdata) : (cnt ? m_rem[c] - 1 : m_rem[c]);
        m_rem[c] = nxt;
        req_e[c] = en && rdy && (nxt != 0);
      end
      m_stat = (m_stat & ~irq_clr) | set_e;
    end
    q.push_back('{cur_tag, 0, req_e});
    q.push_back('{cur_tag, 1, m_stat});
    q.push_back('{cur_tag, 2, {5'd0, (m_stat != 0) || usb_irq_in}});
    @(negedge clk);
  endtask

  // Monitor: compare after each edge, away from it.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (q.size() > 0) begin
        item_t it;
        logic [5:0] got;
        it = q.pop_front();
        got = (it.kind == 0) ? dma_req : (it.kind == 1) ? dma_irq_stat : {5'd0, usb_irq};
        n_cmp++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%b expected=%b at %0t", it.tag, it.kind, got, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL all requirements: watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cur_tag = "R1"; cyc(); cyc();
    rst_n = 1'b1;
    cur_tag = "R1"; cyc();

    // Mapping: ch0->TX ep1, ch1 ep0 (unmapped), ch2->TX ep3 (disabled),
    // ch3->RX ep2, ch4 ep9 (unmapped), ch5->RX ep1.
    set_sel(0, 1); set_sel(1, 0); set_sel(2, 3);
    set_sel(3, 2); set_sel(4, 9); set_sel(5, 1);
    en_tx = 8'b0000_0010; en_rx = 8'b0000_0110;
    md_tx = 8'h00; md_rx = 8'b0000_0100;
    rdy_tx = 8'hFF; rdy_rx = 8'hFF;
    cur_tag = "R3"; cyc();             // ready and enabled, count zero: no request

    len_wr = 6'b111111; len_wdata = 8'd3;
    cur_tag = "R5"; cyc();
    len_wr = '0;
    cur_tag = "R2"; cyc(); cyc();      // only ch0, ch3, ch5 request

    rdy_tx[1] = 1'b0;
    cur_tag = "R4"; cyc();
    rdy_tx[1] = 1'b1;
    cur_tag = "R3"; cyc();

    // Per-packet mode on ch0.
    pkt_done = 6'b000001;
    cur_tag = "R6"; cyc();
    pkt_done = '0; irq_clr = 6'b000001;
    cur_tag = "R8"; cyc();
    irq_clr = '0;
    cur_tag = "R8"; cyc();
    pkt_done = 6'b000001;
    cur_tag = "R6"; cyc(); cyc();      // last packet: request drops
    pkt_done = 6'b000001;
    cur_tag = "R10"; cyc();            // count already zero
    pkt_done = 6'b010010;
    cur_tag = "R10"; cyc();            // unmapped channels
    pkt_done = '0;
    cur_tag = "R9"; cyc();
    irq_clr = 6'b000001;
    cur_tag = "R8"; cyc();
    irq_clr = '0; usb_irq_in = 1'b1;
    cur_tag = "R9"; cyc();
    usb_irq_in = 1'b0;

    // Per-transfer mode on ch3 (RX ep2 mode 1).
    pkt_done = 6'b001000;
    cur_tag = "R7"; cyc(); cyc();
    irq_clr = 6'b001000;
    cur_tag = "R8"; cyc();             // final packet sets while clear is high
    pkt_done = '0; irq_clr = '0;
    cur_tag = "R7"; cyc();
    irq_clr = 6'b001000;
    cur_tag = "R8"; cyc();
    irq_clr = '0;

    // Load beats packet-done on ch0.
    len_wr = 6'b000001; len_wdata = 8'd2; pkt_done = 6'b000001;
    cur_tag = "R5"; cyc();
    len_wr = '0; pkt_done = '0;
    cur_tag = "R5"; cyc();

    // Disable ch5's endpoint mid-transfer; packet-done then ignored.
    en_rx[1] = 1'b0;
    cur_tag = "R4"; cyc();
    pkt_done = 6'b100000;
    cur_tag = "R10"; cyc();
    pkt_done = '0; en_rx[1] = 1'b1;
    cur_tag = "R10"; cyc();            // count intact: request returns

    // Channel 2 disabled endpoint, ready toggling.
    rdy_tx = 8'h00;
    cur_tag = "R4"; cyc();
    rdy_tx = 8'hFF; en_tx[3] = 1'b1;
    cur_tag = "R2"; cyc();
    pkt_done = 6'b100101;
    cur_tag = "R6"; cyc();
    pkt_done = '0; irq_clr = 6'b111111;
    cur_tag = "R8"; cyc(); cyc();

    @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule